// File: doc/BRIEF.md
# Watch Timer with Chained Watchdog

This block is a slow timing subsystem. A watch timer scales the main clock down through a prescaler and a binary divider. It raises a periodic interval interrupt at one of three selectable rates. The same divider drives a watchdog counter. Software must restart the watchdog before it runs out. If it runs out, the block either strobes an interrupt request or strobes a CPU reset, as a mode bit selects.

Software programs the block through two byte-wide control registers on a simple write-strobe bus with combinational read data. The main-clock qualifier `clk_en` is the rate at which the prescaler advances. While `stop` is high, both timers freeze and keep their counts. Counting resumes from the held state when `stop` falls.

The parameters `PRE_DIV` (prescale ratio, default 128) and `DIV_W` (divider width, default 14) set the time base. The rates named below hold for a 4.19 MHz main clock at the defaults.

Top module: `wt_watchdog`

## Requirements
- R1: After reset, register 0 (`addr`=0) reads 8'h00 and register 1 (`addr`=1) reads 8'h12. Unused bits always read 0. Register 0 layout: bit 6 watch enable, bits 3:2 interval code, bits 1:0 source code. Register 1 layout: bit 4 watchdog enable, bits 3:2 timeout code, bit 1 mode, bit 0 clear.
- R2: Only source code 01, with the watch enable set, advances the timers, by one prescaled pulse every `PRE_DIV` cycles in which `clk_en` is high. Source codes 00, 10 and 11 produce no `wt_irq`.
- R3: Interval codes 00, 01 and 10 raise a one-cycle `wt_irq` every 2^(DIV_W-3), 2^(DIV_W-1) and 2^DIV_W prescaled pulses (16 Hz, 4 Hz and 2 Hz at the defaults). Code 11 raises none.
- R4: The watchdog advances once every 2^(DIV_W-2) prescaled pulses (8 Hz). It times out after 16, 8, 4 or 2 such ticks for timeout codes 00, 01, 10 and 11 (2 s, 1 s, 0.5 s and 0.25 s at the defaults).
- R5: A timeout gives a one-cycle `wd_irq` when the mode bit is 0 and a one-cycle `cpu_rst` when it is 1. The two outputs are never high together.
- R6: Writing 1 to the clear bit zeroes the watchdog count. The clear bit always reads 0. A clear in the same cycle as a timeout cancels the timeout.
- R7: The watchdog holds its count and produces no timeout while either the watchdog enable or the watch enable is 0.
- R8: While `stop` is high, the prescaler, the divider and the watchdog hold their state. No interrupt or reset is produced, and counting resumes from the held state after release.
- R9: After a timeout the watchdog count restarts from zero, so an uncleared watchdog times out periodically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Main-clock qualifier feeding the prescaler |
| stop | input | 1 | Freeze request from the STOP power mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 watch control, 1 watchdog control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| wt_irq | output | 1 | Watch interval interrupt strobe |
| wd_irq | output | 1 | Watchdog timeout interrupt strobe |
| cpu_rst | output | 1 | Watchdog timeout reset strobe |

## Verification
The assertions assume `PRE_DIV` is at least 2 and `DIV_W` at least 4, so two watchdog ticks never fall on adjacent cycles. They also assume `stop`, `wr_en` and the data inputs are settled synchronously to `clk`. The bench drives every input on the falling edge and uses a small prescale ratio and divider width, so the intervals stay short. Each period is measured between two consecutive strobes, which makes the checks independent of the divider phase at the moment of configuration.

// File: rtl/wt_watchdog.sv
module wt_watchdog #(
  parameter int PRE_DIV = 128,
  parameter int DIV_W   = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic       stop,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       wt_irq,
  output logic       wd_irq,
  output logic       cpu_rst
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic             wt_en, wd_en, wd_mode;
  logic [1:0]       wt_ival, wt_src, wd_ival;
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       wd_cnt, wd_last;
  logic             run, pulse, wt_hit, tick8, wd_live, clear_wr, timeout;
  logic             wt_irq_q, wd_irq_q, rst_q;

  assign clear_wr = wr_en && addr && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_en   <= 1'b0;
      wt_ival <= 2'b00;
      wt_src  <= 2'b00;
      wd_en   <= 1'b1;
      wd_ival <= 2'b00;
      wd_mode <= 1'b1;
    end else if (wr_en) begin
      if (addr) begin
        wd_en   <= wdata[4];
        wd_ival <= wdata[3:2];
        wd_mode <= wdata[1];
      end else begin
        wt_en   <= wdata[6];
        wt_ival <= wdata[3:2];
        wt_src  <= wdata[1:0];
      end
    end
  end

  assign rdata = addr ? {3'b000, wd_en, wd_ival, wd_mode, 1'b0}
                      : {1'b0, wt_en, 2'b00, wt_ival, wt_src};

  assign run   = wt_en && (wt_src == 2'b01) && !stop && clk_en;
  assign pulse = run && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (run) begin
      pre_q <= pulse ? '0 : pre_q + 1'b1;
      if (pulse) div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    case (wt_ival)
      2'b00:   wt_hit = &div_q[DIV_W-4:0];
      2'b01:   wt_hit = &div_q[DIV_W-2:0];
      2'b10:   wt_hit = &div_q;
      default: wt_hit = 1'b0;
    endcase
  end

  assign tick8   = pulse && (&div_q[DIV_W-3:0]);
  assign wd_live = wd_en && wt_en;
  assign wd_last = 4'(5'd16 >> wd_ival) - 4'd1;
  assign timeout = wd_live && tick8 && (wd_cnt >= wd_last) && !clear_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt   <= '0;
      wt_irq_q <= 1'b0;
      wd_irq_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      if (clear_wr)
        wd_cnt <= '0;
      else if (wd_live && tick8)
        wd_cnt <= (wd_cnt >= wd_last) ? 4'd0 : wd_cnt + 4'd1;
      wt_irq_q <= pulse && wt_hit;
      wd_irq_q <= timeout && !wd_mode;
      rst_q    <= timeout && wd_mode;
    end
  end

  assign wt_irq  = wt_irq_q;
  assign wd_irq  = wd_irq_q;
  assign cpu_rst = rst_q;

  a_r2_source_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wt_irq |-> $past(wt_en && wt_src == 2'b01));
  a_r3_unused_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wt_irq |-> $past(wt_ival != 2'b11));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_irq && cpu_rst));
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |=> !wd_irq);
  a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |=> !cpu_rst);
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear_wr |=> (!wd_irq && !cpu_rst));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_live && !clear_wr) |=> $stable(wd_cnt));
  a_r8_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ($stable(div_q) && $stable(pre_q)));
  a_r8_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!wt_irq && !wd_irq && !cpu_rst));
endmodule

// File: tb/tb_wt_watchdog.sv
module tb_wt_watchdog;
  logic       clk = 0, rst_n = 0, clk_en = 1, stop = 0, wr_en = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       wt_irq, wd_irq, cpu_rst;
  logic       ce_toggle = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wt_watchdog #(.PRE_DIV(2), .DIV_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .stop(stop), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wt_irq(wt_irq),
    .wd_irq(wd_irq), .cpu_rst(cpu_rst));

  // kind 0: wt_irq period, kind 1: wd_irq period; expected cycles with PRE_DIV=2, DIV_W=6
  localparam int VEC [7][3] = '{
    '{0, 0, 16}, '{0, 1, 64}, '{0, 2, 128},
    '{1, 0, 512}, '{1, 1, 256}, '{1, 2, 128}, '{1, 3, 64}};

  initial begin
    forever begin
      @(negedge clk);
      clk_en = ce_toggle ? ~clk_en : 1'b1;
    end
  end

  function automatic logic pick(int sel);
    return (sel == 0) ? wt_irq : (sel == 1) ? wd_irq : cpu_rst;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 0;
  endtask

  task automatic wait_ev(int sel, output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pick(sel)) begin ok = 1; break; end
    end
  endtask

  task automatic measure(int sel, output int per);
    bit ok;
    per = -1;
    wait_ev(sel, ok);
    if (!ok) return;
    for (int i = 1; i < 3000; i++) begin
      @(negedge clk);
      if (pick(sel)) begin per = i; return; end
    end
  endtask

  task automatic count_ev(int sel, int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pick(sel)) cnt++;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, cnt, c2;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    addr = 0; #1 check("R1 reg0 reset", rdata, 8'h00);
    addr = 1; #1 check("R1 reg1 reset", rdata, 8'h12);
    addr = 0;
    count_ev(2, 300, cnt);
    check("R7 watch disabled blocks watchdog", cnt, 0);

    for (int v = 0; v < 7; v++) begin
      if (VEC[v][0] == 0) begin
        wr(1, 8'h00);
        wr(0, 8'h41 | 8'(VEC[v][1] << 2));
        measure(0, per);
        check($sformatf("R3 watch interval code %0d", VEC[v][1]), per, VEC[v][2]);
      end else begin
        wr(0, 8'h4D);
        wr(1, 8'h10 | 8'(VEC[v][1] << 2) | 8'h01);
        measure(1, per);
        check($sformatf("R4 R9 watchdog code %0d", VEC[v][1]), per, VEC[v][2]);
      end
    end

    wr(1, 8'h00);
    wr(0, 8'h40);
    count_ev(0, 200, cnt);
    check("R2 source 00 silent", cnt, 0);
    wr(0, 8'h42);
    count_ev(0, 200, cnt);
    check("R2 source 10 silent", cnt, 0);
    wr(0, 8'h43);
    count_ev(0, 200, cnt);
    check("R2 source 11 silent", cnt, 0);
    wr(0, 8'h4D);
    count_ev(0, 300, cnt);
    check("R3 interval 11 silent", cnt, 0);
    addr = 0; #1 check("R1 reg0 readback", rdata, 8'h4D);

    wr(0, 8'h41);
    ce_toggle = 1;
    measure(0, per);
    check("R2 clk_en qualifies prescaler", per, 32);
    ce_toggle = 0;

    wr(1, 8'h1E);
    wr(0, 8'h4D);
    measure(2, per);
    check("R5 reset mode period", per, 64);
    @(negedge clk);
    check("R5 reset strobe one cycle", cpu_rst, 0);
    wr(1, 8'h1F);
    count_ev(1, 200, cnt);
    check("R5 reset mode no irq", cnt, 0);

    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      wr(1, 8'h1D);
      count_ev(1, 18, c2);
      cnt += c2;
    end
    check("R6 periodic clear prevents timeout", cnt, 0);
    addr = 1; #1 check("R6 clear bit reads 0", rdata, 8'h1C);
    addr = 0;
    measure(1, per);
    check("R6 R9 timeout resumes after clears stop", per, 64);

    wr(1, 8'h0D);
    count_ev(1, 400, cnt);
    check("R7 watchdog enable 0 silent", cnt, 0);
    wr(1, 8'h1D);
    wr(0, 8'h0D);
    count_ev(1, 400, cnt);
    check("R7 watch enable 0 silent", cnt, 0);

    wr(1, 8'h00);
    wr(0, 8'h41);
    wait_ev(0, ok);
    cnt = 0; c2 = 0;
    repeat (5) begin @(negedge clk); cnt++; if (wt_irq) c2++; end
    stop = 1;
    repeat (100) begin @(negedge clk); cnt++; if (wt_irq) c2++; end
    stop = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); cnt++;
      if (wt_irq) break;
    end
    check("R8 no strobe during stop", c2, 0);
    check("R8 resume from held count", cnt, 116);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule